// File: doc/BRIEF.md
# Vector Branch-Condition Evaluator

This block decides whether a vectorised conditional branch is taken. A single 5-bit bit-select operand chooses one bit inside each 4-bit condition field. The field itself comes from a bank of 128 fields. Its index is either held fixed for every element (scalar) or advanced by one for each element (vector). The block walks the elements of the vector at one per cycle. It tests each selected bit against a condition-sense input and reduces the results to one decision.

Two reduction rules are available. In first-success mode, the first passing element takes the branch. In all-pass mode, every counted element must pass. Masked-out elements are handled in one of two ways. Zeroing predication replaces the field with four copies of a substitute bit. Otherwise the element is skipped. In the vector-length-setting variants, the element that decided the outcome also yields a truncated vector length on a write strobe.

A combination that has no defined meaning is reported on a flag instead of producing a result: all-pass mode requested during vertical-first operation. Instruction fetch, target-address arithmetic and step-mode sequencing belong to the surrounding pipeline.

Top module: `vbranch_eval`

## Requirements
- R1: The field index base is `{field_hi, bit_sel[4:2]}` (7 bits). Scalar operation reads that index for every element. Vector operation reads index (base + element) modulo 128. `bit_sel[1:0]` selects bit 0..3 of the 4-bit field that is read.
- R2: `mode[1:0]` gives the kind: 0 normal, 1 VL-set, 2 step, 3 step with VL-set. `mode[3]` selects all-pass and `mode[4]` selects zeroing. In kinds 0 and 2, `mode[2]` is the substitute bit and VL truncation is off. In kinds 1 and 3, `mode[2]` selects inclusive truncation and the substitute bit is 0. Step kinds evaluate exactly like their non-step counterparts.
- R3: An element passes when its selected bit equals `sense`.
- R4: In first-success mode, the branch is taken at the first passing counted element and scanning stops there. If no counted element passes, the branch is not taken.
- R5: In all-pass mode, the branch is taken only if no counted element fails. Scanning stops at the first failure.
- R6: When `pred_en` is 1, zeroing is on and an element's mask bit is 0, the element is tested on a field of four copies of the substitute bit.
- R7: When `pred_en` is 1, zeroing is off and an element's mask bit is 0, the element is skipped and cannot decide the outcome. When `pred_en` is 0, every element counts.
- R8: In VL-set kinds, suppose an element k decides the outcome (first pass or first failure). Then `vl_we` pulses together with `done`, and `vl_new` is k+1 when inclusive truncation is selected, otherwise k. With no deciding element, or in other kinds, `vl_we` stays 0.
- R9: A start with `vert_first` and all-pass both set raises `undef` with `done` in the next cycle, with `taken` 0, no VL write and no scan.
- R10: A start with `vl` = 0 gives `done` in the next cycle, with `taken` equal to the all-pass selection.
- R11: After reset, `done`, `taken`, `undef` and `vl_we` are 0. After a scan that examines n elements, `done` is a one-cycle pulse n cycles after the start cycle. `taken` and `undef` hold until the next accepted start. A start while a scan is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an evaluation; inputs below are captured with it |
| bit_sel | input | 5 | Bit-select operand: [1:0] bit in field, [4:2] low index bits |
| field_hi | input | 4 | Upper four bits of the field index base |
| vec_en | input | 1 | 1: index steps per element; 0: fixed index |
| vl | input | $clog2(MAXVL+1) | Vector length, at most MAXVL |
| pred_en | input | 1 | Predication active |
| pred_mask | input | MAXVL | Per-element predicate bits |
| mode | input | 5 | Mode field, decoded per R2 |
| sense | input | 1 | Value the selected bit must equal to pass |
| vert_first | input | 1 | Vertical-first operation in effect |
| cf_addr | output | 7 | Index of the condition field being read |
| cf_data | input | 4 | Condition field at cf_addr, same cycle |
| taken | output | 1 | Branch decision, valid from done |
| vl_new | output | $clog2(MAXVL+1) | Truncated vector length |
| vl_we | output | 1 | Write strobe for vl_new |
| undef | output | 1 | Undefined combination requested |
| done | output | 1 | Evaluation complete pulse |

## Verification
Three kinds of internal corruption are visible at the ports. A wrong element counter or a wrong field index shows as a wrong field address. That in turn gives a decision taken at the wrong element, which is visible both in `taken` and in `done` arriving a different number of cycles after the start. A wrongly latched mode bit flips the reduction rule or the substitute value, and the outcome changes at the very done pulse of that evaluation. A fault in the truncation path shows as a `vl_new` that differs by one from the deciding position, or as a stray or missing `vl_we` beside `done`. Every such error is observable no later than the done pulse of the affected evaluation.

// File: rtl/vbr_pkg.sv
// Package: shared types and constants for the vector branch-condition evaluator.
// Assumes a 128-entry bank of 4-bit condition fields.
package vbr_pkg;
    localparam int FIELD_W    = 4;
    localparam int NUM_FIELDS = 128;
    localparam int FIDX_W     = $clog2(NUM_FIELDS);

    // Kind of evaluation selected by the two low mode bits
    typedef enum logic [1:0] {
        K_NORMAL     = 2'b00,
        K_VLSET      = 2'b01,
        K_STEP       = 2'b10,
        K_STEP_VLSET = 2'b11
    } kind_e;

    // Decoded mode controls
    typedef struct packed {
        logic vlset;     // truncate VL at the deciding element
        logic all_pass;  // every counted element must pass
        logic zeroing;   // masked elements use substitute field
        logic snz;       // substitute bit value
        logic vli;       // inclusive truncation
    } mode_cfg_t;
endpackage

// File: rtl/vbr_mode_dec.sv
// Mode decoder: turns the 5-bit mode field into control bits.
// Assumes step kinds evaluate like their non-step counterparts; bit 2 is
// the substitute bit in non-VL-set kinds and the inclusive flag otherwise.
module vbr_mode_dec
    import vbr_pkg::*;
(
    input  logic [4:0] mode,
    output mode_cfg_t  cfg
);
    kind_e kind;

    // Split the mode field into its controls
    always_comb begin
        kind         = kind_e'(mode[1:0]);
        cfg.vlset    = (kind == K_VLSET) || (kind == K_STEP_VLSET);
        cfg.all_pass = mode[3];
        cfg.zeroing  = mode[4];
        cfg.snz      = cfg.vlset ? 1'b0 : mode[2];
        cfg.vli      = cfg.vlset ? mode[2] : 1'b0;
    end
endmodule

// File: rtl/vbr_elem_test.sv
// Element tester: applies predication to one condition field and tests
// the selected bit against the sense value. Purely combinational.
// Assumes the caller qualifies the outputs with its own busy state.
module vbr_elem_test
    import vbr_pkg::*;
(
    input  logic [FIELD_W-1:0] field,
    input  logic [1:0]         bit_pick,
    input  logic               pred_on,
    input  logic               pred_bit,
    input  logic               zeroing,
    input  logic               snz,
    input  logic               sense,
    output logic               counts,
    output logic               pass
);
    logic               masked;
    logic [FIELD_W-1:0] eff;

    // Substitute or skip masked elements, then compare the chosen bit
    always_comb begin
        masked = pred_on && !pred_bit;
        eff    = (masked && zeroing) ? {FIELD_W{snz}} : field;
        counts = !(masked && !zeroing);
        pass   = (eff[bit_pick] == sense);
    end
endmodule

// File: rtl/vbr_scan_ctl.sv
// Scan controller: steps the element counter one per cycle, stops on the
// deciding element or after the last one, and registers the results.
// Assumes vl_in <= MAXVL and that configuration inputs are latched
// by the parent on the accepted start.
module vbr_scan_ctl #(
    parameter int MAXVL = 64,
    localparam int VLW  = $clog2(MAXVL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [VLW-1:0] vl_in,
    input  logic           all_in,
    input  logic           undef_req,
    input  logic [VLW-1:0] vl_q,
    input  logic           all_q,
    input  logic           vlset_q,
    input  logic           vli_q,
    input  logic           elem_counts,
    input  logic           elem_pass,
    output logic           accept,
    output logic           busy,
    output logic [VLW-1:0] idx,
    output logic           taken,
    output logic [VLW-1:0] vl_new,
    output logic           vl_we,
    output logic           undef,
    output logic           done
);
    logic last;
    logic decide;

    // Accept, last-element and decision terms for this cycle
    always_comb begin
        accept = start && !busy;
        last   = (idx == vl_q - VLW'(1));
        decide = busy && elem_counts && (all_q ? !elem_pass : elem_pass);
    end

    // Sequence the scan and register the outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            taken  <= 1'b0;
            vl_new <= '0;
            vl_we  <= 1'b0;
            undef  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done  <= 1'b0;
            vl_we <= 1'b0;
            if (accept) begin
                taken <= 1'b0;
                undef <= 1'b0;
                idx   <= '0;
                if (undef_req) begin
                    undef <= 1'b1;
                    done  <= 1'b1;
                end else if (vl_in == '0) begin
                    taken <= all_in;
                    done  <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (busy) begin
                if (decide) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    taken <= !all_q;
                    if (vlset_q) begin
                        vl_we  <= 1'b1;
                        vl_new <= vli_q ? idx + VLW'(1) : idx;
                    end
                end else if (last) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    taken <= all_q;
                end else begin
                    idx <= idx + VLW'(1);
                end
            end
        end
    end

    a_r11_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx < vl_q));
    a_r8_we_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        vl_we |-> done);
    a_r8_we_only_vlset: assert property (@(posedge clk) disable iff (!rst_n)
        vl_we |-> vlset_q);
    a_r8_vlnew_bound: assert property (@(posedge clk) disable iff (!rst_n)
        vl_we |-> (vl_new <= vl_q));
    a_r9_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        undef |-> (!taken && !vl_we));
    a_r9_undef_next: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && undef_req) |=> (done && undef && !busy));
    a_r10_empty_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !undef_req && vl_in == '0) |=> (done && taken == $past(all_in)));
    a_r11_no_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
endmodule

// File: rtl/vbranch_eval.sv
// Vector branch-condition evaluator top: latches the operands on an
// accepted start, forms the field address per element, and reduces the
// element tests to a branch decision through the scan controller.
// Assumes the condition-field bank answers cf_addr in the same cycle and
// that vl never exceeds MAXVL.
module vbranch_eval
    import vbr_pkg::*;
#(
    parameter int MAXVL = 64,
    localparam int VLW  = $clog2(MAXVL + 1),
    localparam int IDXW = $clog2(MAXVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [4:0]        bit_sel,
    input  logic [3:0]        field_hi,
    input  logic              vec_en,
    input  logic [VLW-1:0]    vl,
    input  logic              pred_en,
    input  logic [MAXVL-1:0]  pred_mask,
    input  logic [4:0]        mode,
    input  logic              sense,
    input  logic              vert_first,
    output logic [FIDX_W-1:0] cf_addr,
    input  logic [FIELD_W-1:0] cf_data,
    output logic              taken,
    output logic [VLW-1:0]    vl_new,
    output logic              vl_we,
    output logic              undef,
    output logic              done
);
    mode_cfg_t         cfg_in;
    mode_cfg_t         cfg_q;
    logic [FIDX_W-1:0] base_q;
    logic [1:0]        pick_q;
    logic              vec_q;
    logic              pred_en_q;
    logic [MAXVL-1:0]  pmask_q;
    logic              sense_q;
    logic [VLW-1:0]    vl_q;
    logic              accept;
    logic              busy;
    logic [VLW-1:0]    idx;
    logic              elem_counts;
    logic              elem_pass;

    vbr_mode_dec u_dec (
        .mode (mode),
        .cfg  (cfg_in)
    );

    // Capture the operands on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q     <= '0;
            base_q    <= '0;
            pick_q    <= '0;
            vec_q     <= 1'b0;
            pred_en_q <= 1'b0;
            pmask_q   <= '0;
            sense_q   <= 1'b0;
            vl_q      <= '0;
        end else if (accept) begin
            cfg_q     <= cfg_in;
            base_q    <= {field_hi, bit_sel[4:2]};
            pick_q    <= bit_sel[1:0];
            vec_q     <= vec_en;
            pred_en_q <= pred_en;
            pmask_q   <= pred_mask;
            sense_q   <= sense;
            vl_q      <= vl;
        end
    end

    // Field address: fixed in scalar operation, stepped in vector operation
    always_comb begin
        cf_addr = vec_q ? base_q + FIDX_W'(idx) : base_q;
    end

    vbr_elem_test u_test (
        .field    (cf_data),
        .bit_pick (pick_q),
        .pred_on  (pred_en_q),
        .pred_bit (pmask_q[idx[IDXW-1:0]]),
        .zeroing  (cfg_q.zeroing),
        .snz      (cfg_q.snz),
        .sense    (sense_q),
        .counts   (elem_counts),
        .pass     (elem_pass)
    );

    vbr_scan_ctl #(.MAXVL(MAXVL)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .vl_in       (vl),
        .all_in      (cfg_in.all_pass),
        .undef_req   (vert_first && cfg_in.all_pass),
        .vl_q        (vl_q),
        .all_q       (cfg_q.all_pass),
        .vlset_q     (cfg_q.vlset),
        .vli_q       (cfg_q.vli),
        .elem_counts (elem_counts),
        .elem_pass   (elem_pass),
        .accept      (accept),
        .busy        (busy),
        .idx         (idx),
        .taken       (taken),
        .vl_new      (vl_new),
        .vl_we       (vl_we),
        .undef       (undef),
        .done        (done)
    );

    a_r11_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(cfg_q) && $stable(vl_q) && $stable(base_q)));
    a_r1_scalar_addr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !vec_q && $past(busy)) |-> $stable(cf_addr));
endmodule

// File: tb/tb_vbranch_eval.sv
`timescale 1ns/1ps
module tb_vbranch_eval;
    localparam int MAXVL = 64;
    localparam int VLW   = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [4:0]       bit_sel = '0;
    logic [3:0]       field_hi = '0;
    logic             vec_en = 1'b0;
    logic [VLW-1:0]   vl = '0;
    logic             pred_en = 1'b0;
    logic [MAXVL-1:0] pred_mask = '0;
    logic [4:0]       mode = '0;
    logic             sense = 1'b0;
    logic             vert_first = 1'b0;
    logic [6:0]       cf_addr;
    logic [3:0]       cf_data;
    logic             taken;
    logic [VLW-1:0]   vl_new;
    logic             vl_we;
    logic             undef;
    logic             done;

    logic [3:0] bank [128];
    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign cf_data = bank[cf_addr];

    vbranch_eval #(.MAXVL(MAXVL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_sel(bit_sel),
        .field_hi(field_hi), .vec_en(vec_en), .vl(vl), .pred_en(pred_en),
        .pred_mask(pred_mask), .mode(mode), .sense(sense),
        .vert_first(vert_first), .cf_addr(cf_addr), .cf_data(cf_data),
        .taken(taken), .vl_new(vl_new), .vl_we(vl_we), .undef(undef),
        .done(done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_bank();
        for (int i = 0; i < 128; i++) bank[i] = 4'b0000;
    endtask

    // Build a mode word: sz, all, bit2, kind
    function automatic logic [4:0] mk(input bit sz, input bit all, input bit b2, input int kind);
        return {sz, all, b2, kind[1:0]};
    endfunction

    // Apply one evaluation, predict it from the requirements, check it
    task automatic run_case(input string req, input logic [4:0] bs, input logic [3:0] hi,
                            input bit vec, input int vlen, input bit pen,
                            input logic [63:0] pm, input logic [4:0] md, input bit sns,
                            input bit vf, input bit mid);
        bit all, vls, sz, snz, vli, dec, e_taken, e_undef, e_we;
        int k, lat, n;
        logic [6:0] base, a;
        logic [3:0] f;
        all = md[3]; sz = md[4]; vls = md[0];
        snz = vls ? 1'b0 : md[2];
        vli = vls ? md[2] : 1'b0;
        base = {hi, bs[4:2]};
        dec = 0; k = 0; e_undef = 0; e_we = 0;
        if (vf && all) begin
            e_undef = 1; e_taken = 0; lat = 0;
        end else if (vlen == 0) begin
            e_taken = all; lat = 0;
        end else begin
            for (int e = 0; e < vlen; e++) begin
                a = vec ? base + 7'(e) : base;
                f = bank[a];
                if (pen && !pm[e]) begin
                    if (!sz) continue;
                    f = {4{snz}};
                end
                if (all ? (f[bs[1:0]] != sns) : (f[bs[1:0]] == sns)) begin
                    dec = 1; k = e; break;
                end
            end
            lat = dec ? k + 1 : vlen;
            e_taken = dec ? !all : all;
            e_we = dec && vls;
        end
        @(negedge clk);
        bit_sel = bs; field_hi = hi; vec_en = vec; vl = VLW'(vlen);
        pred_en = pen; pred_mask = pm; mode = md; sense = sns;
        vert_first = vf; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        n = 0;
        if (mid && !done) begin
            start = 1'b1; mode = md ^ 5'b01000; sense = ~sns; vl = 7'd1;
        end
        while (!done && n < 300) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        chk(req, "done latency", n, lat);
        chk(req, "taken", int'(taken), int'(e_taken));
        chk(req, "undef", int'(undef), int'(e_undef));
        chk(req, "vl_we", int'(vl_we), int'(e_we));
        if (e_we) chk(req, "vl_new", int'(vl_new), vli ? k + 1 : k);
        @(negedge clk);
        chk("R11", "done pulse ends", int'(done), 0);
        chk("R11", "taken held", int'(taken), int'(e_taken));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "reset done", int'(done), 0);
        chk("R11", "reset taken", int'(taken), 0);
        chk("R11", "reset vl_we", int'(vl_we), 0);
        chk("R11", "reset undef", int'(undef), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_scalar();
        clear_bank();
        bank[21] = 4'b0100;   // R1 field {2,5}, bit 2 set; R3 pass on sense 1
        run_case("R1", {3'd5, 2'd2}, 4'h2, 0, 3, 0, '0, mk(0,0,0,0), 1, 0, 0);
        run_case("R3", {3'd5, 2'd2}, 4'h2, 0, 3, 0, '0, mk(0,0,0,0), 0, 0, 0);
        run_case("R1", {3'd5, 2'd1}, 4'h2, 0, 3, 0, '0, mk(0,0,0,0), 1, 0, 0);
    endtask

    task automatic t_vector_first();
        clear_bank();
        bank[15] = 4'b0010;   // base 10, element 5, bit 1
        run_case("R4", {3'd2, 2'd1}, 4'h1, 1, 8, 0, '0, mk(0,0,0,0), 1, 0, 0);
        run_case("R4", {3'd2, 2'd0}, 4'h1, 1, 8, 0, '0, mk(0,0,0,0), 1, 0, 0);
        run_case("R4", {3'd2, 2'd1}, 4'h1, 1, 5, 0, '0, mk(0,0,0,0), 1, 0, 0);
    endtask

    task automatic t_all();
        clear_bank();
        for (int i = 30; i < 36; i++) bank[i] = 4'b1000;
        run_case("R5", {3'd6, 2'd3}, 4'h3, 1, 6, 0, '0, mk(0,1,0,0), 1, 0, 0);
        bank[32] = 4'b0000;
        run_case("R5", {3'd6, 2'd3}, 4'h3, 1, 6, 0, '0, mk(0,1,0,0), 1, 0, 0);
    endtask

    task automatic t_zeroing();
        // field 32 cleared, element 2 masked
        run_case("R6", {3'd6, 2'd3}, 4'h3, 1, 6, 1, 64'hFFFF_FFFF_FFFF_FFFB, mk(1,1,1,0), 1, 0, 0);
        run_case("R6", {3'd6, 2'd3}, 4'h3, 1, 6, 1, 64'hFFFF_FFFF_FFFF_FFFB, mk(1,1,0,0), 1, 0, 0);
        run_case("R2", {3'd6, 2'd3}, 4'h3, 1, 6, 1, 64'hFFFF_FFFF_FFFF_FFFB, mk(1,1,1,2), 1, 0, 0);
        run_case("R2", {3'd6, 2'd3}, 4'h3, 1, 6, 1, 64'hFFFF_FFFF_FFFF_FFFB, mk(1,1,1,1), 1, 0, 0);
    endtask

    task automatic t_skip();
        run_case("R7", {3'd6, 2'd3}, 4'h3, 1, 6, 1, 64'hFFFF_FFFF_FFFF_FFFB, mk(0,1,0,0), 1, 0, 0);
        clear_bank();
        bank[15] = 4'b0010;
        run_case("R7", {3'd2, 2'd1}, 4'h1, 1, 8, 1, 64'hFFFF_FFFF_FFFF_FFDF, mk(0,0,0,0), 1, 0, 0);
        run_case("R7", {3'd2, 2'd1}, 4'h1, 1, 8, 0, 64'hFFFF_FFFF_FFFF_FFDF, mk(0,0,0,0), 1, 0, 0);
    endtask

    task automatic t_vlset();
        clear_bank();
        bank[15] = 4'b0010;
        run_case("R8", {3'd2, 2'd1}, 4'h1, 1, 8, 0, '0, mk(0,0,1,1), 1, 0, 0);
        run_case("R8", {3'd2, 2'd1}, 4'h1, 1, 8, 0, '0, mk(0,0,0,1), 1, 0, 0);
        run_case("R8", {3'd2, 2'd1}, 4'h1, 1, 8, 0, '0, mk(0,0,1,0), 1, 0, 0);
        run_case("R8", {3'd2, 2'd1}, 4'h1, 1, 4, 0, '0, mk(0,0,1,3), 1, 0, 0);
        for (int i = 30; i < 36; i++) bank[i] = 4'b1000;
        bank[32] = 4'b0000;
        run_case("R8", {3'd6, 2'd3}, 4'h3, 1, 6, 0, '0, mk(0,1,1,3), 1, 0, 0);
    endtask

    task automatic t_undef();
        run_case("R9", {3'd6, 2'd3}, 4'h3, 1, 6, 0, '0, mk(0,1,0,0), 1, 1, 0);
        run_case("R9", {3'd6, 2'd3}, 4'h3, 1, 6, 0, '0, mk(0,0,0,1), 1, 1, 0);
    endtask

    task automatic t_empty();
        run_case("R10", {3'd6, 2'd3}, 4'h3, 1, 0, 0, '0, mk(0,0,0,0), 1, 0, 0);
        run_case("R10", {3'd6, 2'd3}, 4'h3, 1, 0, 0, '0, mk(0,1,0,0), 1, 0, 0);
    endtask

    task automatic t_busy_start();
        clear_bank();
        bank[15] = 4'b0010;
        run_case("R11", {3'd2, 2'd1}, 4'h1, 1, 8, 0, '0, mk(0,0,1,1), 1, 0, 1);
    endtask

    task automatic t_wrap();
        clear_bank();
        bank[1] = 4'b0001;    // base 127 plus element 2 wraps to 1
        run_case("R1", {3'd7, 2'd0}, 4'hF, 1, 4, 0, '0, mk(0,0,1,1), 1, 0, 0);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        clear_bank();
        t_reset();
        t_scalar();
        t_vector_first();
        t_all();
        t_zeroing();
        t_skip();
        t_vlset();
        t_undef();
        t_empty();
        t_busy_start();
        t_wrap();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule